// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer register operand into an IEEE binary64 value. A 2-bit type select says how the operand is read: signed or unsigned, and 32 or 64 bits wide. A precision select chooses between two results. One is a true double. The other is rounded to binary32 precision and then re-encoded losslessly in double format. A 2-bit rounding mode controls every conversion that can lose bits.

The result comes with a 5-bit class code and three rounding status bits: fraction-rounded (`flag_fr`), fraction-inexact (`flag_fi`) and inexact-exception (`flag_xx`). A `status_we` strobe says whether those status values belong to the current result. A 32-bit source converted to a double is always exact, so that path leaves the class and status outputs untouched.

A conversion launched with `in_valid` appears one cycle later with `out_valid`. A two-state controller tracks this:
- `ST_IDLE`: no result is presented.
- `ST_OUT`: a result is presented.

Transitions:
- `ST_IDLE -> ST_OUT` on `in_valid`.
- `ST_OUT -> ST_OUT` on `in_valid`.
- `ST_OUT -> ST_IDLE` when `in_valid` is low.
- `ST_IDLE -> ST_IDLE` when `in_valid` is low.

Top module: `int_to_fp_conv`

## Requirements
- R1: `int_kind` selects the source type: 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit. `result` is binary64: sign in bit 63, exponent in bits 62:52 with bias 1023, fraction in bits 51:0.
- R2: For `int_kind` 0 and 1, bits 63:32 of `operand` have no effect on any output.
- R3: When `to_single`=0 and `int_kind` is 0 or 1, the result is exact. `status_we` is 0, and `class_code`, `flag_fr`, `flag_fi` and `flag_xx` keep their previous values.
- R4: For every other combination, `status_we` is 1 and all status outputs are computed fresh from this conversion alone.
- R5: `rmode` selects the rounding: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. Toward zero never raises `flag_fr`.
- R6: With `to_single`=1, the value is rounded to a 24-bit significand. `result` is that binary32 value widened to binary64, so `result[28:0]` is zero.
- R7: `flag_fr` is 1 when rounding raised the magnitude. `flag_fi` and `flag_xx` are both 1 when the result differs from the integer.
- R8: `class_code` is 5'b00010 for +0, 5'b00100 for a positive normal and 5'b01000 for a negative normal. No other value appears when status is written.
- R9: A zero operand gives all-zero `result` (+0.0). The most negative signed value of each width converts exactly, to minus a power of two.
- R10: `out_valid` is 1 exactly one cycle after `in_valid` is 1. Under reset, `out_valid`, `status_we`, `result`, `class_code` and the flags are all zero.
- R11: When rounding up carries out of the significand, the exponent rises by one and the fraction becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start a conversion this cycle |
| operand | input | 64 | Integer source |
| int_kind | input | 2 | Source type select |
| to_single | input | 1 | 1: round to binary32 and widen; 0: binary64 |
| rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | binary64 result |
| class_code | output | 5 | Class of the rounded result |
| flag_fr | output | 1 | Magnitude was rounded up |
| flag_fi | output | 1 | Result is inexact |
| flag_xx | output | 1 | Inexact exception flag |
| status_we | output | 1 | Status outputs are to be written |

## Verification
A wrong leading-bit position or a misplaced guard or sticky bit shows up in `result` in the cycle after the offending `in_valid`. It shows as a wrong exponent, a fraction off by one unit, or a missed or spurious `flag_fr`. A controller that loses or gains a cycle shows at `out_valid` on the very next edge. A hold path that leaks on the exact route changes `class_code` or a flag while `status_we` is low, again one cycle after launch. Large operands that straddle the rounding point, mixed with both precisions and all four modes, expose each of these within a single conversion.

// File: rtl/int_fp_pkg.sv
`timescale 1ns/1ps
package int_fp_pkg;
    localparam int OP_W      = 64;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int EXP_BIAS  = 1023;
    localparam int DBL_SIG_W = FRAC_W + 1;
    localparam int SGL_SIG_W = 24;
    localparam int POS_W     = $clog2(OP_W);
    localparam int PAD_W     = DBL_SIG_W - SGL_SIG_W;
    localparam int CLS_W     = 5;

    typedef enum logic [1:0] {
        KIND_S32 = 2'd0,
        KIND_U32 = 2'd1,
        KIND_S64 = 2'd2,
        KIND_U64 = 2'd3
    } int_kind_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } conv_state_e;

    localparam logic [CLS_W-1:0] CLS_POS_ZERO = 5'b00010;
    localparam logic [CLS_W-1:0] CLS_POS_NORM = 5'b00100;
    localparam logic [CLS_W-1:0] CLS_NEG_NORM = 5'b01000;
endpackage

// File: rtl/int_fp_sign_mag.sv
`timescale 1ns/1ps
module int_fp_sign_mag
    import int_fp_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic [W-1:0] op,
    input  int_kind_e    kind,
    output logic         neg,
    output logic [W-1:0] mag
);
    localparam int H = W / 2;

    logic [H-1:0] lo;
    assign lo = op[H-1:0];

    always_comb begin
        unique case (kind)
            KIND_S32: begin
                neg = lo[H-1];
                mag = {{H{1'b0}}, (lo[H-1] ? H'(~lo + 1'b1) : lo)};
            end
            KIND_U32: begin
                neg = 1'b0;
                mag = {{H{1'b0}}, lo};
            end
            KIND_S64: begin
                neg = op[W-1];
                mag = op[W-1] ? W'(~op + 1'b1) : op;
            end
            default: begin
                neg = 1'b0;
                mag = op;
            end
        endcase
    end
endmodule

// File: rtl/int_fp_normalize.sv
`timescale 1ns/1ps
module int_fp_normalize
    import int_fp_pkg::*;
#(
    parameter int W   = OP_W,
    parameter int P_W = $clog2(W)
) (
    input  logic [W-1:0]   mag,
    output logic [P_W-1:0] top_pos,
    output logic [W-1:0]   norm
);
    always_comb begin
        top_pos = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) top_pos = P_W'(i);
        end
        norm = mag << (P_W'(W - 1) - top_pos);
    end
endmodule

// File: rtl/int_fp_round.sv
`timescale 1ns/1ps
module int_fp_round
    import int_fp_pkg::*;
#(
    parameter int W     = OP_W,
    parameter int SIG_W = DBL_SIG_W
) (
    input  logic [W-1:0]     norm,
    input  logic             neg,
    input  rmode_e           rmode,
    output logic [SIG_W-2:0] frac,
    output logic             hidden,
    output logic             carry,
    output logic             inc,
    output logic             inexact
);
    localparam int G_POS = W - 1 - SIG_W;

    logic           lsb, guard, sticky;
    logic [SIG_W:0] sum;

    always_comb begin
        lsb     = norm[W-SIG_W];
        guard   = norm[G_POS];
        sticky  = |norm[G_POS-1:0];
        inexact = guard | sticky;
        unique case (rmode)
            RM_NEAREST: inc = guard & (sticky | lsb);
            RM_ZERO:    inc = 1'b0;
            RM_UP:      inc = inexact & ~neg;
            RM_DOWN:    inc = inexact & neg;
        endcase
        sum    = {1'b0, norm[W-1 -: SIG_W]} + (SIG_W + 1)'(inc);
        carry  = sum[SIG_W];
        hidden = sum[SIG_W-1];
        frac   = sum[SIG_W-2:0];
    end
endmodule

// File: rtl/int_to_fp_conv.sv
`timescale 1ns/1ps
module int_to_fp_conv
    import int_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  operand,
    input  logic [1:0]       int_kind,
    input  logic             to_single,
    input  logic [1:0]       rmode,
    output logic             out_valid,
    output logic [OP_W-1:0]  result,
    output logic [CLS_W-1:0] class_code,
    output logic             flag_fr,
    output logic             flag_fi,
    output logic             flag_xx,
    output logic             status_we
);
    conv_state_e state_q, state_d;

    logic            neg;
    logic [OP_W-1:0] mag, norm;
    logic [POS_W-1:0] top_pos;

    int_fp_sign_mag #(.W(OP_W)) u_sm (
        .op(operand), .kind(int_kind_e'(int_kind)), .neg(neg), .mag(mag)
    );

    int_fp_normalize #(.W(OP_W), .P_W(POS_W)) u_norm (
        .mag(mag), .top_pos(top_pos), .norm(norm)
    );

    logic [FRAC_W-1:0] frac_p   [2];
    logic              hidden_p [2];
    logic              carry_p  [2];
    logic              inc_p    [2];
    logic              inexact_p[2];

    for (genvar p = 0; p < 2; p++) begin : g_prec
        localparam int SW = (p == 0) ? DBL_SIG_W : SGL_SIG_W;
        logic [SW-2:0] r_frac;
        int_fp_round #(.W(OP_W), .SIG_W(SW)) u_rnd (
            .norm(norm), .neg(neg), .rmode(rmode_e'(rmode)),
            .frac(r_frac), .hidden(hidden_p[p]), .carry(carry_p[p]),
            .inc(inc_p[p]), .inexact(inexact_p[p])
        );
        assign frac_p[p] = FRAC_W'(r_frac) << (DBL_SIG_W - SW);
    end

    logic             sel, is_zero, exact_path;
    logic [POS_W:0]   exp_unb;
    logic [EXP_W-1:0] exp_biased;
    logic [OP_W-1:0]  res_d;
    logic [CLS_W-1:0] cls_d;

    always_comb begin
        sel        = to_single;
        is_zero    = ~(hidden_p[sel] | carry_p[sel]);
        exp_unb    = {1'b0, top_pos} + (POS_W + 1)'(carry_p[sel]);
        exp_biased = EXP_W'(exp_unb) + EXP_W'(EXP_BIAS);
        res_d      = is_zero ? '0 : {neg, exp_biased, frac_p[sel]};
        cls_d      = is_zero ? CLS_POS_ZERO : (neg ? CLS_NEG_NORM : CLS_POS_NORM);
        exact_path = ~to_single & ~int_kind[1];
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_OUT : ST_IDLE;
            ST_OUT:  state_d = in_valid ? ST_OUT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_OUT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            class_code <= '0;
            flag_fr    <= 1'b0;
            flag_fi    <= 1'b0;
            flag_xx    <= 1'b0;
            status_we  <= 1'b0;
        end else if (in_valid) begin
            result    <= res_d;
            status_we <= ~exact_path;
            if (!exact_path) begin
                class_code <= cls_d;
                flag_fr    <= inc_p[sel];
                flag_fi    <= inexact_p[sel];
                flag_xx    <= inexact_p[sel];
            end
        end else begin
            status_we <= 1'b0;
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_exact_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !status_we) |-> ($stable(class_code) && $stable(flag_fr)
                                       && $stable(flag_fi) && $stable(flag_xx)));
    assert_status_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (to_single || int_kind[1])) |=> status_we);
    assert_rz_no_bump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode == 2'd1 && (to_single || int_kind[1])) |=> !flag_fr);
    assert_single_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && to_single) |=> (result[PAD_W-1:0] == '0));
    assert_fr_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && flag_fr) |-> (flag_fi && flag_xx));
    assert_class_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> (class_code == CLS_POS_ZERO || class_code == CLS_POS_NORM
                       || class_code == CLS_NEG_NORM));
    assert_zero_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_we && result == '0) |-> (class_code == CLS_POS_ZERO && !flag_fi));
endmodule

// File: tb/sim_int_to_fp_conv.sv
`timescale 1ns/1ps
module sim_int_to_fp_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  int_kind = '0;
    logic        to_single = 1'b0;
    logic [1:0]  rmode = '0;
    logic        out_valid, flag_fr, flag_fi, flag_xx, status_we;
    logic [63:0] result;
    logic [4:0]  class_code;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [4:0] hold_cls = '0;
    logic       hold_fr = 1'b0;
    logic       hold_fi = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    int_to_fp_conv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .int_kind(int_kind), .to_single(to_single), .rmode(rmode),
        .out_valid(out_valid), .result(result), .class_code(class_code),
        .flag_fr(flag_fr), .flag_fi(flag_fi), .flag_xx(flag_xx),
        .status_we(status_we)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] op, input logic [1:0] k,
                                  input logic sg, input logic [1:0] rm,
                                  output logic [63:0] res, output logic [4:0] cls,
                                  output logic up, output logic inx);
        logic        neg;
        logic [63:0] mag, sig, rem, half;
        int          p, sz, sh;
        neg = 1'b0;
        case (k)
            2'd0: begin
                neg = op[31];
                mag = neg ? (64'h1_0000_0000 - {32'b0, op[31:0]}) : {32'b0, op[31:0]};
            end
            2'd1: mag = {32'b0, op[31:0]};
            2'd2: begin
                neg = op[63];
                mag = neg ? (64'd0 - op) : op;
            end
            default: mag = op;
        endcase
        up = 1'b0;
        inx = 1'b0;
        if (mag == 0) begin
            res = '0;
            cls = 5'b00010;
            return;
        end
        p = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) p = i;
        sz = sg ? 24 : 53;
        if (p < sz) begin
            sig = mag << (sz - 1 - p);
        end else begin
            sh   = p - (sz - 1);
            sig  = mag >> sh;
            rem  = mag & ((64'd1 << sh) - 1);
            half = 64'd1 << (sh - 1);
            inx  = (rem != 0);
            case (rm)
                2'd0: up = (rem > half) || (rem == half && sig[0]);
                2'd1: up = 1'b0;
                2'd2: up = inx && !neg;
                default: up = inx && neg;
            endcase
        end
        if (up) sig = sig + 1;
        if (sig == (64'd1 << sz)) begin
            sig = sig >> 1;
            p++;
        end
        res = {neg, 11'(p + 1023), 52'((sig & ((64'd1 << (sz - 1)) - 1)) << (53 - sz))};
        cls = neg ? 5'b01000 : 5'b00100;
    endfunction

    task automatic run(input logic [63:0] op, input logic [1:0] k, input logic sg,
                       input logic [1:0] rm, input string tag);
        logic [63:0] e_res;
        logic [4:0]  e_cls;
        logic        e_up, e_inx, exact;
        @(negedge clk);
        operand = op; int_kind = k; to_single = sg; rmode = rm; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(op, k, sg, rm, e_res, e_cls, e_up, e_inx);
        exact = !sg && !k[1];
        if (!exact) begin
            hold_cls = e_cls; hold_fr = e_up; hold_fi = e_inx;
        end
        chk(out_valid == 1'b1, {tag, " R10 out_valid"}, 64'(out_valid), 64'd1);
        chk(result == e_res, {tag, " R1 result"}, result, e_res);
        chk(status_we == !exact, {tag, " R3/R4 status_we"}, 64'(status_we), 64'(!exact));
        chk(class_code == hold_cls, {tag, " R8 class"}, 64'(class_code), 64'(hold_cls));
        chk(flag_fr == hold_fr, {tag, " R7 fr"}, 64'(flag_fr), 64'(hold_fr));
        chk(flag_fi == hold_fi && flag_xx == hold_fi, {tag, " R7 fi/xx"},
            64'({flag_fi, flag_xx}), 64'({hold_fi, hold_fi}));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && status_we == 0 && result == 0 && class_code == 0
            && !flag_fr && !flag_fi && !flag_xx,
            "R10 reset state", result, 64'd0);
        rst_n = 1'b1;

        run(64'd0, 2'd2, 1'b0, 2'd0, "R9 zero");
        chk(result == 64'd0 && class_code == 5'b00010, "R9 zero literal", result, 64'd0);
        run(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd0, "R9 min s64");
        chk(result == 64'hC3E0_0000_0000_0000, "R9 min s64 literal", result,
            64'hC3E0_0000_0000_0000);
        run(64'hFFFF_FFFF_8000_0000, 2'd0, 1'b0, 2'd2, "R3 min s32 exact");
        chk(result == 64'hC1E0_0000_0000_0000, "R9 min s32 literal", result,
            64'hC1E0_0000_0000_0000);
        run(64'hDEAD_BEEF_0000_0005, 2'd1, 1'b0, 2'd0, "R2 upper ignored");
        chk(result == 64'h4014_0000_0000_0000, "R2 upper ignored literal", result,
            64'h4014_0000_0000_0000);
        run(64'h1234_5678_FFFF_FFFD, 2'd0, 1'b1, 2'd0, "R2 s32 single");
        chk(result == 64'hC008_0000_0000_0000 && class_code == 5'b01000,
            "R2 minus three literal", result, 64'hC008_0000_0000_0000);
        for (int m = 0; m < 4; m++) begin
            run(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'(m), "R5 tie-break double");
        end
        chk(result == 64'h4340_0000_0000_0000, "R5 down literal", result,
            64'h4340_0000_0000_0000);
        run(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd2, "R5 up");
        chk(result == 64'h4340_0000_0000_0001 && flag_fr, "R5 up literal", result,
            64'h4340_0000_0000_0001);
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0, "R11 carry");
        chk(result == 64'h43F0_0000_0000_0000, "R11 carry literal", result,
            64'h43F0_0000_0000_0000);
        run(64'h0000_0000_0100_0001, 2'd1, 1'b1, 2'd2, "R6 single up");
        chk(result == 64'h4170_0000_2000_0000, "R6 single literal", result,
            64'h4170_0000_2000_0000);
        run(64'h0000_0000_0100_0003, 2'd0, 1'b1, 2'd3, "R6 single down");
        run(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 2'd3, "R9 minus one single");
        run(64'h0000_0000_0000_0007, 2'd1, 1'b0, 2'd1, "R3 exact hold");
        @(negedge clk);
        chk(out_valid == 1'b0 && status_we == 1'b0, "R10 idle after gap",
            64'(out_valid), 64'd0);

        for (int n = 0; n < 600; n++) begin
            logic [63:0] op;
            case ($urandom % 4)
                0: op = {$urandom, $urandom};
                1: op = 64'($urandom % 1000);
                2: op = {$urandom, $urandom} >> ($urandom % 64);
                default: op = ~({$urandom, $urandom} >> ($urandom % 64));
            endcase
            run(op, 2'($urandom), 1'($urandom), 2'($urandom), "R1 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule